// File: doc/BRIEF.md
# Dual-Oscillator Supply-Drop Monitor

This block watches a protected supply rail by comparing the rates of two free-running ring oscillators. One oscillator runs from the internal supply of a cryptographic core. The other runs from a scaled copy of the external supply. An attacker can pull the internal rail down on purpose, so that the core's current signature shows through an attenuation stage. When that happens, the internal oscillator slows down relative to the external one. The block counts both oscillators over a window and raises an alarm when the difference leaves a programmed band.

Each raw oscillator first drives its own ripple chain of toggle flops, which divides it down. The divided signal is brought into the system clock domain, and its rising edges are counted there. While monitoring is enabled, a window counter marks off a programmed number of system cycles. At the end of each window the block forms the signed difference external count minus internal count. It compares that difference with an upper and a lower limit, then restarts both counts.

Every pin is a plain control or status level. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. Configuration values are sampled on every cycle and should only be changed while monitoring is disabled.

Top module: `supply_drop_monitor`

## Requirements
- R1: Each oscillator is divided by 2^DIV_STAGES (default 3 stages, divide by 8) in a chain of toggle flops. Each divided signal passes through a two-flop synchronizer, and one count is added for each of its rising edges.
- R2: While `mon_en_i` is low, both edge counts are held at zero and no edges are accumulated.
- R3: On the W-th consecutive rising clock edge with `mon_en_i` high, where W = `win_cycles_i` (unsigned), the block evaluates D = external count minus internal count. D is signed and at least 17 bits wide. The limits `limit_hi_i` and `limit_lo_i` are 16-bit two's complement values. The alarm is set when D > `limit_hi_i` or D < `limit_lo_i`. A value of D equal to either limit does not set the alarm.
- R4: No evaluation happens before the first complete window. If `mon_en_i` drops before the window completes, the partial window is discarded, and the next window starts afresh when enable returns.
- R5: A window length of zero disables evaluation entirely, so the alarm can never be set.
- R6: Once set, `alarm_o` stays high, even if later windows fall inside the band, until it is cleared.
- R7: With `alarm_clr_i` high and no failing evaluation in the same cycle, `alarm_o` is low after the next clock edge. A failing evaluation in the same cycle as a clear takes priority and leaves the alarm set.
- R8: After each evaluation both counts restart from zero, so every window is judged on its own edges only.
- R9: After reset `alarm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_int_i | input | 1 | Raw oscillator on the internal supply |
| osc_ext_i | input | 1 | Raw oscillator on the scaled external supply |
| mon_en_i | input | 1 | Enables windowed evaluation |
| win_cycles_i | input | 16 | Window length in system cycles (0 disables) |
| limit_hi_i | input | 16 | Signed upper limit on the count difference |
| limit_lo_i | input | 16 | Signed lower limit on the count difference |
| alarm_clr_i | input | 1 | Clears the sticky alarm |
| alarm_o | output | 1 | Sticky supply-drop alarm |

## Verification
The embedded assertions check several properties on every cycle. Counts are held at zero while monitoring is idle. Each count advances by at most one per cycle. A synchronized edge pulse lasts exactly one cycle. The alarm is sticky and clears as R7 requires. A zero-length window never produces a trip. Other behaviour can only be shown by the bench scenarios, because it depends on the real frequency ratio between the two oscillators. That includes the band decision at both limits, the exact cycle on which the first window closes, the discarding of a partial window, and the independence of successive windows. The bench also has a tied-oscillator case, which fixes the difference at exactly zero and so probes the inclusive limit boundary.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int CFG_W  = 16;
  localparam int DIFF_W = CFG_W + 1;

  typedef logic [CFG_W-1:0]         cfg_t;
  typedef logic signed [DIFF_W-1:0] diff_t;

  function automatic diff_t widen_signed(input cfg_t v);
    return diff_t'({v[CFG_W-1], v});
  endfunction

  function automatic diff_t count_gap(input cfg_t a, input cfg_t b);
    return diff_t'({1'b0, a}) - diff_t'({1'b0, b});
  endfunction
endpackage

// File: rtl/sdm_ripple_divider.sv
module sdm_ripple_divider #(
  parameter int STAGES = 3
) (
  input  logic rst_ni,
  input  logic osc_i,
  output logic div_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge osc_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= 1'b0;
          else         stage_q[0] <= ~stage_q[0];
        end
      end else begin : g_next
        always_ff @(negedge stage_q[g-1] or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= ~stage_q[g];
        end
      end
    end
  endgenerate

  assign div_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdm_edge_counter.sv
module sdm_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic sync1_q, sync2_q, last_q;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      sync1_q <= div_i;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (rise)  cnt_o <= cnt_o + 1'b1;
  end

  // R1: a synchronized rising edge is a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);

  // R1: the count never advances by more than one per cycle
  a_r1_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/sdm_window_judge.sv
module sdm_window_judge
  import sdm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  cfg_t win_i,
  input  cfg_t hi_i,
  input  cfg_t lo_i,
  input  logic clr_i,
  input  cfg_t cnt_ext_i,
  input  cfg_t cnt_int_i,
  output logic cnt_clr_o,
  output logic alarm_o
);
  cfg_t  win_q;
  logic  win_end;
  logic  trip;
  diff_t gap;

  assign win_end   = en_i && (win_i != '0) && (win_q == win_i - 1'b1);
  assign cnt_clr_o = !en_i || win_end;
  assign gap       = count_gap(cnt_ext_i, cnt_int_i);
  assign trip      = win_end &&
                     ((gap > widen_signed(hi_i)) || (gap < widen_signed(lo_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (!en_i)   win_q <= '0;
    else if (win_end) win_q <= '0;
    else if (win_i != '0) win_q <= win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    alarm_o <= 1'b0;
    else if (trip)  alarm_o <= 1'b1;
    else if (clr_i) alarm_o <= 1'b0;
  end

  // R2: counts are held at zero while monitoring is idle
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_ext_i == '0) && (cnt_int_i == '0));

  // R6: alarm holds without a clear
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !clr_i |=> alarm_o);

  // R7: a clear without a coincident trip drops the alarm
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !trip |=> !alarm_o);

  // R5: zero-length window never trips
  a_r5_zero_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i == '0) |-> !trip);

  // R4: the alarm can only rise from an enabled cycle
  a_r4_rise_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(en_i));
endmodule

// File: rtl/supply_drop_monitor.sv
module supply_drop_monitor
  import sdm_pkg::*;
#(
  parameter int DIV_STAGES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_int_i,
  input  logic        osc_ext_i,
  input  logic        mon_en_i,
  input  logic [15:0] win_cycles_i,
  input  logic [15:0] limit_hi_i,
  input  logic [15:0] limit_lo_i,
  input  logic        alarm_clr_i,
  output logic        alarm_o
);
  localparam int NPATH = 2;

  logic [NPATH-1:0] osc_raw;
  logic [NPATH-1:0] osc_div;
  cfg_t             cnt [NPATH];
  logic             cnt_clr;

  assign osc_raw = {osc_ext_i, osc_int_i};

  genvar p;
  generate
    for (p = 0; p < NPATH; p++) begin : g_path
      sdm_ripple_divider #(.STAGES(DIV_STAGES)) u_div (
        .rst_ni (rst_ni),
        .osc_i  (osc_raw[p]),
        .div_o  (osc_div[p])
      );
      sdm_edge_counter #(.CNT_W(CFG_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (osc_div[p]),
        .clr_i  (cnt_clr),
        .cnt_o  (cnt[p])
      );
    end
  endgenerate

  sdm_window_judge u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mon_en_i),
    .win_i     (win_cycles_i),
    .hi_i      (limit_hi_i),
    .lo_i      (limit_lo_i),
    .clr_i     (alarm_clr_i),
    .cnt_ext_i (cnt[1]),
    .cnt_int_i (cnt[0]),
    .cnt_clr_o (cnt_clr),
    .alarm_o   (alarm_o)
  );
endmodule

// File: tb/supply_drop_monitor_tb.sv
`timescale 1ns/1ps
module supply_drop_monitor_tb;
  localparam int  DIV = 3;
  localparam real TCLK = 5.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ro_int = 1'b0, ro_ext_free = 1'b0, tie = 1'b1;
  logic en = 1'b0, clr = 1'b0;
  logic [15:0] win = 16'd0, hi = 16'd0, lo = 16'd0;
  logic alarm;
  real  half_int = 3.0, half_ext = 3.0;
  int   errors = 0, checks = 0;
  logic done = 1'b0;

  wire ro_ext = tie ? ro_int : ro_ext_free;

  always #(TCLK/2.0) clk = ~clk;
  initial forever #(half_int) ro_int = ~ro_int;
  initial forever #(half_ext) ro_ext_free = ~ro_ext_free;

  supply_drop_monitor #(.DIV_STAGES(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_int_i(ro_int), .osc_ext_i(ro_ext),
    .mon_en_i(en), .win_cycles_i(win), .limit_hi_i(hi), .limit_lo_i(lo),
    .alarm_clr_i(clr), .alarm_o(alarm));

  function automatic real exp_gap(input int w, input real hint, input real hext);
    real div;
    div = real'(2 ** DIV);
    return (w * TCLK) / (div * 2.0 * hext) - (w * TCLK) / (div * 2.0 * hint);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: alarm=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_and_clear();
    en = 1'b0; clr = 1'b1; edges(1); clr = 1'b0; edges(20);
  endtask

  // enable at a negedge; alarm should change exactly after edge W
  task automatic window_run(input string req, input int w, input logic expect_trip);
    en = 1'b1;
    edges(w - 1);
    check({req, " before window end"}, alarm, 1'b0);
    edges(2);
    check(req, alarm, expect_trip);
  endtask

  initial begin
    void'($urandom(32'h5DA1));
    edges(3);
    check("R9 reset", alarm, 1'b0);
    rst_n = 1'b1;
    edges(5);
    check("R9 after reset", alarm, 1'b0);

    // R3 boundary with tied oscillators: difference is exactly zero
    win = 16'd200; hi = 16'd0; lo = 16'd0;
    window_run("R3 equal to both limits", 200, 1'b0);
    idle_and_clear();
    hi = 16'hFFFF; lo = 16'h8000;  // hi = -1
    window_run("R3 above upper limit -1", 200, 1'b1);
    idle_and_clear();
    check("R7 clear", alarm, 1'b0);
    hi = 16'd5; lo = 16'd1;
    window_run("R3 below lower limit", 200, 1'b1);
    idle_and_clear();
    tie = 1'b0;

    // random trials
    for (int t = 0; t < 10; t++) begin
      int w, dr, kind;
      real g;
      half_int = $urandom_range(20, 60) / 10.0;
      half_ext = $urandom_range(20, 60) / 10.0;
      w = $urandom_range(300, 600);
      g = exp_gap(w, half_int, half_ext);
      dr = $rtoi(g >= 0 ? g + 0.5 : g - 0.5);
      kind = t % 3;
      win = 16'(w);
      if (kind == 0) begin lo = 16'(dr - 4); hi = 16'(dr + 4); end
      else if (kind == 1) begin hi = 16'(dr - 5); lo = 16'h8000; end
      else begin lo = 16'(dr + 5); hi = 16'h7FFF; end
      idle_and_clear();
      window_run(kind == 0 ? "R1 R3 inside band" :
                 (kind == 1 ? "R3 upper trip" : "R3 lower trip"), w, kind != 0);
      if (kind == 0) begin
        edges(2 * w);
        check("R8 later windows stay in band", alarm, 1'b0);
      end
    end

    // R4: partial window discarded; R2 counts restart on re-enable
    half_int = 6.0; half_ext = 2.5;
    win = 16'd400; hi = 16'(-10); lo = 16'h8000; // any real gap (~+28) trips
    idle_and_clear();
    en = 1'b1; edges(390); en = 1'b0; edges(10);
    check("R4 partial window no trip", alarm, 1'b0);
    edges(5);
    window_run("R2 R4 fresh window trips", 400, 1'b1);

    // R6: sticky after conditions become passing
    hi = 16'h7FFF; lo = 16'h8000;
    edges(900);
    check("R6 sticky", alarm, 1'b1);

    // R7: clear coinciding with a trip keeps alarm
    idle_and_clear();
    hi = 16'(-10); lo = 16'h8000;
    en = 1'b1; edges(399); clr = 1'b1; edges(1); clr = 1'b0;
    check("R7 trip beats clear", alarm, 1'b1);

    // R5: zero window
    idle_and_clear();
    win = 16'd0;
    en = 1'b1; edges(1500);
    check("R5 zero window never trips", alarm, 1'b0);
    en = 1'b0;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * TCLK);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule